// File: doc/BRIEF.md
# Length-Prefixed FIFO Loopback Slot

This block is an accelerator slot that copies data unchanged from an input queue to an output queue. The host pushes a transfer into the input queue. The first word of a transfer is a control word: an unsigned count of the data words that follow it. The control word is consumed and is never forwarded. The engine then moves exactly that many words into the output queue, in order and unmodified. After the last of them, it raises a completion flag that stays high until reset, which tells the host that the output queue can be drained.

The engine talks to its two queues through a nine-signal slot interface: clock, reset, input data, input empty, input read enable, output data, output write enable, output full and done. Both queues are first-word-fall-through, so the head word is visible while the queue is not empty, and a read enable pops it in the same cycle it is captured. The engine never looks at the output full flag. The host must keep each transfer within the output queue depth. The slot handles one transfer per reset.

Top module: `lpb_slot`

## Requirements
- R1: While reset (active low, synchronous) is held and on the first cycle after its release, `done` is 0 and `host_empty` is 1. Reset also empties both queues and returns the engine to waiting.
- R2: While the input queue is empty, the engine reads nothing, writes nothing and keeps `done` at 0. It never pops an empty input queue.
- R3: The first word pushed after reset is the control word. It is read as an unsigned 32-bit count N of the data words that follow, and it never appears at the output.
- R4: The N data words that follow the control word appear at `host_rdata` in push order, with every bit unchanged.
- R5: Words pushed after the Nth data word are not forwarded. Once the N words are drained, `host_empty` stays 1.
- R6: `done` stays 0 until all N data words have been read from the input queue. It then rises, and it stays 1 until reset. After `done` rises there are no further reads or writes.
- R7: A control word of 0 leads to `done` with no word written to the output queue.
- R8: If data words arrive with gaps, or arrive long after the control word, the engine waits for them. The output is the same as when all words are pushed at once.
- R9: A transfer of exactly the output queue depth (16 words by default) completes and drains intact, even if the host pops nothing before `done`. The engine does not consult the output full flag.
- R10: A reset in the middle of a transfer discards it. `done` goes back to 0, the output queue is emptied, and the next control word starts a new transfer from a count of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_push | input | 1 | Push `host_wdata` into the input queue |
| host_wdata | input | 32 | Word pushed by the host (control word or data) |
| host_full | output | 1 | Input queue is full |
| host_pop | input | 1 | Pop the head of the output queue |
| host_rdata | output | 32 | Head of the output queue (valid while `host_empty` is 0) |
| host_empty | output | 1 | Output queue is empty |
| done | output | 1 | Sticky flag: the transfer is complete |

## Verification
Assertions check the following properties on every cycle:
- The engine never pops an empty input queue.
- Each output write carries the word popped on the previous cycle.
- `done` is sticky, and no traffic happens once `done` is high.
- The read count never passes the stored size.
- A zero control word reaches `done` two cycles after the count is stored.
- Writes never hit a full output queue.

Some properties can only be shown by the bench's scenarios, because they depend on whole transfers:
- Exactly N words come out, with the right values and in the right order, for every N from 0 up to the output depth.
- Trailing words stay behind.
- The result does not depend on how the input words are paced.
- A reset in the middle of a transfer leaves no residue.

// File: rtl/lpb_pkg.sv
// Package: lpb_pkg
// Shared definitions for the loopback slot. It holds the engine state
// encoding, which the engine uses and which its assertions refer to.
package lpb_pkg;

    // Engine control states, listed in the order the engine steps through them
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_SIZE   = 3'd1,
        ST_SAVE_SIZE = 3'd2,
        ST_CHECK     = 3'd3,
        ST_RD_DATA   = 3'd4,
        ST_WR_DATA   = 3'd5,
        ST_DONE      = 3'd6
    } lpb_state_e;

endpackage

// File: rtl/lpb_fifo.sv
// Module: lpb_fifo
// Synchronous first-word-fall-through queue. The head entry is shown on
// rdata whenever empty is 0, and pop retires it on the clock edge.
// Assumptions: DEPTH >= 2. A push while full and a pop while empty are
// dropped; the assertions flag both as misuse. Reset is synchronous and
// active low. It clears the pointers and the level, but not the storage.
module lpb_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q, wr_nx, rd_nx;
    logic [LVL_W-1:0] lvl_q;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Pointer advance: a power-of-two depth wraps by itself, any other depth wraps explicitly
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
            assign wr_nx = wr_q + 1'b1;
            assign rd_nx = rd_q + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_nx = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
            assign rd_nx = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
        end
    endgenerate

    // Storage write on an accepted push
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= wdata;
        end
    end

    // Pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_nx;
            if (do_pop)  rd_q <= rd_nx;
            case ({do_push, do_pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // Head presentation and flags
    assign rdata = mem[rd_q];
    assign full  = (lvl_q == FULL_LVL);
    assign empty = (lvl_q == '0);

    // R2: callers never pop an empty queue
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R9: callers never push into a full queue
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/lpb_engine.sv
// Module: lpb_engine
// Control engine of the loopback slot. It reads a leading control word
// (the count of data words), then copies that many words from the input
// queue to the output queue and raises a sticky done flag.
// Assumptions: both queues are first-word-fall-through. in_rd_en pops the
// head, which is captured in the same cycle. out_full is not consulted,
// because the host keeps each transfer within the output depth. The engine
// handles one transfer per reset.
module lpb_engine
    import lpb_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SIZE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_empty,
    output logic              in_rd_en,
    output logic [WORD_W-1:0] out_data,
    output logic              out_wr_en,
    input  logic              out_full,
    output logic              done
);

    lpb_state_e        state_q, state_d;
    logic [WORD_W-1:0] hold_q;
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] cnt_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (!in_empty) state_d = ST_RD_SIZE;
            ST_RD_SIZE:   state_d = ST_SAVE_SIZE;
            ST_SAVE_SIZE: state_d = ST_CHECK;
            ST_CHECK: begin
                if (cnt_q == size_q)  state_d = ST_DONE;
                else if (!in_empty)   state_d = ST_RD_DATA;
            end
            ST_RD_DATA:   state_d = ST_WR_DATA;
            ST_WR_DATA:   state_d = ST_CHECK;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture of the popped word, whether control or data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state_q == ST_RD_SIZE || state_q == ST_RD_DATA) begin
            hold_q <= in_data;
        end
    end

    // Size register and read counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            cnt_q  <= '0;
        end else if (state_q == ST_SAVE_SIZE) begin
            size_q <= hold_q[SIZE_W-1:0];
            cnt_q  <= '0;
        end else if (state_q == ST_RD_DATA) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Slot interface outputs decoded from the state
    assign in_rd_en  = (state_q == ST_RD_SIZE) || (state_q == ST_RD_DATA);
    assign out_wr_en = (state_q == ST_WR_DATA);
    assign out_data  = hold_q;
    assign done      = (state_q == ST_DONE);

    // R2: the engine pops only a queue that holds a word
    assert_pop_guarded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |-> !in_empty);

    // R4: every output write carries the word popped on the previous cycle
    assert_copy_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> ($past(in_rd_en) && out_data == $past(in_data)));

    // R5: the read count never passes the stored size
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= size_q);

    // R6: once raised, done holds
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R6: no traffic after completion
    assert_quiet_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!in_rd_en && !out_wr_en));

    // R7: a zero count reaches done two cycles after it is stored
    assert_zero_to_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAVE_SIZE && hold_q[SIZE_W-1:0] == '0) |=> ##1 done);

    // R9: the host sizing rule holds, so no write lands on a full output queue
    assert_fits_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> !out_full);

endmodule

// File: rtl/lpb_slot.sv
// Module: lpb_slot
// Top of the loopback slot. The host pushes into the input queue, the
// engine moves a length-prefixed transfer across, and the host pops the
// output queue once done is high.
// Assumptions: synchronous active-low reset. A transfer holds at most
// OUT_DEPTH data words. Each transfer plus its control word fits IN_DEPTH.
module lpb_slot #(
    parameter int WORD_W    = 32,
    parameter int SIZE_W    = 32,
    parameter int IN_DEPTH  = 32,
    parameter int OUT_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_push,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              host_full,
    input  logic              host_pop,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_empty,
    output logic              done
);

    logic [WORD_W-1:0] in_data, out_data;
    logic              in_empty, in_rd_en, out_wr_en, out_full;

    // Input queue: host pushes, engine pops
    lpb_fifo #(.WIDTH(WORD_W), .DEPTH(IN_DEPTH)) u_in_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (host_push),
        .wdata (host_wdata),
        .full  (host_full),
        .pop   (in_rd_en),
        .rdata (in_data),
        .empty (in_empty)
    );

    // Control engine on the nine-signal slot interface
    lpb_engine #(.WORD_W(WORD_W), .SIZE_W(SIZE_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_empty  (in_empty),
        .in_rd_en  (in_rd_en),
        .out_data  (out_data),
        .out_wr_en (out_wr_en),
        .out_full  (out_full),
        .done      (done)
    );

    // Output queue: engine pushes, host pops
    lpb_fifo #(.WIDTH(WORD_W), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (out_wr_en),
        .wdata (out_data),
        .full  (out_full),
        .pop   (host_pop),
        .rdata (host_rdata),
        .empty (host_empty)
    );

    // R1: on the first cycle out of reset, the slot is idle and the output is empty
    assert_reset_state_R1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (!done && host_empty));

endmodule

// File: tb/lpb_slot_test.sv
module lpb_slot_test;

    localparam int WORD_W    = 32;
    localparam int IN_DEPTH  = 32;
    localparam int OUT_DEPTH = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_push = 1'b0;
    logic [WORD_W-1:0] host_wdata = '0;
    logic              host_full;
    logic              host_pop = 1'b0;
    logic [WORD_W-1:0] host_rdata;
    logic              host_empty;
    logic              done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    lpb_slot #(.WORD_W(WORD_W), .SIZE_W(32), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_push(host_push), .host_wdata(host_wdata), .host_full(host_full),
        .host_pop(host_pop), .host_rdata(host_rdata), .host_empty(host_empty),
        .done(done)
    );

    always #2 clk = ~clk;  // 250 MHz

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int n, input int i);
        return 32'hC3A50000 ^ (32'(n) * 32'h01000193) ^ (32'(i) * 32'h00010101);
    endfunction

    // All tasks start and end at a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        host_push = 1'b0;
        host_pop = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && host_empty, "R1 reset hold", {30'd0, done, host_empty}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && host_empty, "R1 after release", {30'd0, done, host_empty}, 32'd1);
    endtask

    task automatic push_word(input logic [31:0] w);
        host_push = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_push = 1'b0;
    endtask

    task automatic wait_done(input int limit, input string tag);
        int k = 0;
        while (!done && k < limit) begin
            @(negedge clk);
            k++;
        end
        check(done, tag, {31'd0, done}, 32'd1);
    endtask

    task automatic drain(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            check(!host_empty, {tag, " R4 word present"}, {31'd0, host_empty}, 32'd0);
            check(host_rdata == pattern(n, i), {tag, " R4 data"}, host_rdata, pattern(n, i));
            host_pop = 1'b1;
            @(negedge clk);
            host_pop = 1'b0;
        end
        check(host_empty, {tag, " R3/R5 no extra output"}, {31'd0, host_empty}, 32'd1);
    endtask

    // mode 0: all words at once plus trailing words; 1: gaps; 2: long delay before data
    task automatic run_transfer(input int n, input int mode);
        string tag;
        tag = $sformatf("n=%0d mode=%0d", n, mode);
        do_reset();
        push_word(32'(n));
        if (mode == 2) begin
            repeat (12) @(negedge clk);
            if (n > 0)
                check(!done && host_empty, {tag, " R8 waits for data"}, {30'd0, done, host_empty}, 32'd1);
        end
        for (int i = 0; i < n; i++) begin
            if (mode == 1) begin
                repeat (4) @(negedge clk);
                if (i == n - 1)
                    check(!done, {tag, " R6 no early done"}, {31'd0, done}, 32'd0);
            end
            push_word(pattern(n, i));
        end
        if (mode == 0) begin
            push_word(32'hDEAD0001);
            push_word(32'hDEAD0002);
        end
        wait_done(3 * n + 40, {tag, " R6 done raised"});
        repeat (6) @(negedge clk);
        check(done, {tag, " R6 done sticky"}, {31'd0, done}, 32'd1);
        drain(n, tag);
        repeat (10) @(negedge clk);
        check(host_empty, {tag, " R5 trailing words held back"}, {31'd0, host_empty}, 32'd1);
        check(done, {tag, " R6 done still high"}, {31'd0, done}, 32'd1);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2: idle with an empty input queue
        repeat (20) @(negedge clk);
        check(!done && host_empty, "R2 idle with no input", {30'd0, done, host_empty}, 32'd1);

        // R7: zero control word followed by a stray word
        do_reset();
        push_word(32'd0);
        push_word(32'hBEEF0000);
        wait_done(40, "R7 zero count done");
        repeat (10) @(negedge clk);
        check(host_empty, "R7 zero count writes nothing", {31'd0, host_empty}, 32'd1);

        // R4/R8/R9: sweep every length up to the output depth under each pacing
        for (int mode = 0; mode < 3; mode++)
            for (int n = 0; n <= OUT_DEPTH; n++)
                run_transfer(n, mode);

        // R10: reset in the middle of a transfer, then a fresh transfer
        do_reset();
        push_word(32'd10);
        for (int i = 0; i < 3; i++) push_word(32'h11110000 + 32'(i));
        repeat (15) @(negedge clk);
        check(!done, "R10 mid-transfer not done", {31'd0, done}, 32'd0);
        check(!host_empty, "R10 partial output present", {31'd0, host_empty}, 32'd0);
        do_reset();
        check(host_empty && !done, "R10 reset clears", {30'd0, done, host_empty}, 32'd1);
        push_word(32'd2);
        push_word(pattern(2, 0));
        push_word(pattern(2, 1));
        wait_done(60, "R10 fresh transfer done");
        drain(2, "R10 fresh");

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule